// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm and Rate Trim

This peripheral keeps time as a plain 32-bit count of seconds. A prescaler divides a fast input clock down to a one-per-second tick. The prescaler length comes from a divider/trim register, and a signed trim field stretches or shortens one tick interval out of every group of ticks to correct the long-term rate. Each tick advances the seconds count and latches a tick-event flag. When the count reaches the value held in the alarm register, an alarm-event flag latches.

Software reaches the four registers through a simple single-cycle read/write port. A parameter selects one of two address layouts. The status register holds two interrupt enables and the two event flags. The flags clear only when software writes a one to them. Two level interrupt outputs report each flag gated by its enable.

Top module: `sec_rtc`

## Requirements
- R1: After reset the seconds count, alarm, status and divider/trim registers all read zero, and both interrupt outputs are low.
- R2: The seconds count reads back what software wrote to it. It rises by one on each tick. A software write in the same cycle as a tick wins, and the increment is lost.
- R3: With a divider/trim value D (bits 15:0) and a non-zero register, ticks are D+1 input clocks apart. While the whole register is zero, no tick occurs and the count holds.
- R4: The interval that ends each group of TRIM_GROUP ticks (1024 by default) lasts D+1+T clocks, with a floor of one clock. T is the signed 16-bit field in bits 31:16.
- R5: Every tick sets the tick-event flag (status bit 1), whether or not its enable is set.
- R6: The alarm-event flag (status bit 0) sets on the tick whose new count equals the alarm register. It then stays set until it is cleared.
- R7: Writing a one to status bit 1 or bit 0 clears that flag, and writing a zero leaves it unchanged. Bits 3 (tick enable) and 2 (alarm enable) are plain read/write bits. Bits 31:4 read zero.
- R8: hz_irq is high exactly when status bits 1 and 3 are both set, and alarm_irq is high exactly when bits 0 and 2 are both set. Both are registered and change on the same edge as the flag or enable that drives them.
- R9: With LAYOUT=0 the count, alarm, status and divider/trim registers sit at 0x00, 0x04, 0x08 and 0x0C. With LAYOUT=1 the alarm, count, divider/trim and status registers sit at 0x00, 0x04, 0x08 and 0x10. Reads of any other offset return zero.
- R10: A write to the divider/trim register restarts the prescaler and the trim group. The first tick after the write comes D+1 clocks after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hz_irq | output | 1 | Tick interrupt level |
| alarm_irq | output | 1 | Alarm interrupt level |

## Verification
A register write takes effect at the clock edge that samples it. A tick's effects (count, flags and interrupt levels) all appear at the edge where the prescaler reaches the end of its interval, with no added pipeline stage. The bench therefore counts edges from the divider/trim write that restarts the prescaler, and samples on the falling edge just before and just after each due edge. This pins each result to a single cycle. Long trim groups are measured the same way, by counting the edges to the 1024th tick.

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int LAYOUT     = 0,
  parameter int TRIM_GROUP = 1024,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              hz_irq,
  output logic              alarm_irq
);

  localparam logic [ADDR_W-1:0] OFF_CNT  = (LAYOUT == 0) ? ADDR_W'(8'h00) : ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_ALM  = (LAYOUT == 0) ? ADDR_W'(8'h04) : ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_STAT = (LAYOUT == 0) ? ADDR_W'(8'h08) : ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_TRIM = (LAYOUT == 0) ? ADDR_W'(8'h0C) : ADDR_W'(8'h08);
  localparam int GRP_W = (TRIM_GROUP > 2) ? $clog2(TRIM_GROUP) : 1;
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(TRIM_GROUP - 1);

  logic [31:0] cnt, alarm, trdiv;
  logic        hze, ale, hzf, alf;
  logic [17:0] pre;
  logic [GRP_W-1:0] grp;

  wire we       = bus_sel & bus_wr;
  wire hit_cnt  = we && (bus_addr == OFF_CNT);
  wire hit_alm  = we && (bus_addr == OFF_ALM);
  wire hit_stat = we && (bus_addr == OFF_STAT);
  wire hit_trim = we && (bus_addr == OFF_TRIM);

  wire               active   = (trdiv != 32'd0);
  wire [17:0]        base_len = {2'b00, trdiv[15:0]} + 18'd1;
  wire signed [17:0] adj_len  = $signed(base_len) + $signed({{2{trdiv[31]}}, trdiv[31:16]});
  wire [17:0]        trim_len = (adj_len < 18'sd1) ? 18'd1 : 18'(adj_len);
  wire [17:0]        len      = (grp == GRP_LAST) ? trim_len : base_len;
  wire               tick     = active && (pre == len - 18'd1);

  logic [31:0] cnt_nx;
  logic        hzf_nx, alf_nx, hze_nx, ale_nx;

  always_comb begin
    cnt_nx = cnt;
    if (hit_cnt)   cnt_nx = bus_wdata;
    else if (tick) cnt_nx = cnt + 32'd1;
    hze_nx = hit_stat ? bus_wdata[3] : hze;
    ale_nx = hit_stat ? bus_wdata[2] : ale;
    hzf_nx = tick | (hzf & ~(hit_stat & bus_wdata[1]));
    alf_nx = (tick && cnt_nx == alarm) | (alf & ~(hit_stat & bus_wdata[0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      grp <= '0;
    end else if (hit_trim || !active) begin
      pre <= '0;
      grp <= '0;
    end else if (tick) begin
      pre <= '0;
      grp <= (grp == GRP_LAST) ? '0 : grp + 1'b1;
    end else begin
      pre <= pre + 18'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; alarm <= '0; trdiv <= '0;
      hze <= 1'b0; ale <= 1'b0; hzf <= 1'b0; alf <= 1'b0;
      hz_irq <= 1'b0; alarm_irq <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (hit_alm)  alarm <= bus_wdata;
      if (hit_trim) trdiv <= bus_wdata;
      hze <= hze_nx; ale <= ale_nx; hzf <= hzf_nx; alf <= alf_nx;
      hz_irq    <= hzf_nx & hze_nx;
      alarm_irq <= alf_nx & ale_nx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_CNT)  bus_rdata = cnt;
    if (bus_addr == OFF_ALM)  bus_rdata = alarm;
    if (bus_addr == OFF_STAT) bus_rdata = {28'd0, hze, ale, hzf, alf};
    if (bus_addr == OFF_TRIM) bus_rdata = trdiv;
  end

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_irq == (hzf & hze)) && (alarm_irq == (alf & ale)));
  assert_tick_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> hzf);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit_cnt) |=> (cnt == $past(cnt) + 32'd1));
  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hit_cnt) |=> $stable(cnt));
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trdiv == 32'd0) |-> !tick);
  assert_alarm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alf && !(hit_stat && bus_wdata[0])) |=> alf);

endmodule

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic hz_a, al_a, hz_b, al_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sec_rtc #(.LAYOUT(0)) dut (.clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .hz_irq(hz_a), .alarm_irq(al_a));
  sec_rtc #(.LAYOUT(1)) dut_alt (.clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b), .hz_irq(hz_b), .alarm_irq(al_b));

  localparam logic [4:0] A_CNT = 5'h00, A_ALM = 5'h04, A_STAT = 5'h08, A_TRIM = 5'h0C;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input bit alt, input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    if (alt) sel_b = 1'b1; else sel_a = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
  endtask

  task automatic rd(input bit alt, input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = alt ? rdata_b : rdata_a;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset;
    logic [31:0] v;
    rd(0, A_CNT, v);  chk("R1 count", v, 0);
    rd(0, A_ALM, v);  chk("R1 alarm", v, 0);
    rd(0, A_STAT, v); chk("R1 status", v, 0);
    rd(0, A_TRIM, v); chk("R1 trim", v, 0);
    chk("R1 irqs", {30'd0, hz_a, al_a}, 0);
  endtask

  task automatic test_idle;
    logic [31:0] v;
    wait_neg(20);
    rd(0, A_CNT, v);  chk("R3 no tick while zero", v, 0);
    rd(0, A_STAT, v); chk("R3 no flag while zero", v, 0);
  endtask

  task automatic test_prescale;
    logic [31:0] v;
    wr_reg(0, A_TRIM, 32'h0000_0003);
    wait_neg(3);
    rd(0, A_CNT, v); chk("R10 before first tick", v, 0);
    wait_neg(1);
    rd(0, A_CNT, v); chk("R3 first tick", v, 1);
    rd(0, A_STAT, v); chk("R5 tick flag set", v & 32'h2, 32'h2);
    chk("R8 hz_irq gated off", {31'd0, hz_a}, 0);
    wait_neg(3);
    wr_reg(0, A_CNT, 32'd100);
    rd(0, A_CNT, v); chk("R2 write beats tick", v, 100);
    wait_neg(3);
    rd(0, A_CNT, v); chk("R3 holds between ticks", v, 100);
    wait_neg(1);
    rd(0, A_CNT, v); chk("R2 increment after write", v, 101);
  endtask

  task automatic test_status;
    logic [31:0] v;
    wr_reg(0, A_TRIM, 32'h0);
    wr_reg(0, A_STAT, 32'h0);
    rd(0, A_STAT, v); chk("R7 zero write keeps flag", v, 32'h2);
    wr_reg(0, A_STAT, 32'hFFFF_FFFC);
    rd(0, A_STAT, v); chk("R7 enables set, upper bits zero", v, 32'hE);
    chk("R8 hz_irq on", {31'd0, hz_a}, 1);
    wr_reg(0, A_STAT, 32'hA);
    rd(0, A_STAT, v); chk("R7 one clears flag", v, 32'h8);
    chk("R8 hz_irq off after clear", {31'd0, hz_a}, 0);
  endtask

  task automatic test_alarm;
    logic [31:0] v;
    wr_reg(0, A_STAT, 32'h3);
    wr_reg(0, A_CNT, 32'd5);
    wr_reg(0, A_ALM, 32'd7);
    wr_reg(0, A_TRIM, 32'h0000_0003);
    wait_neg(7);
    rd(0, A_STAT, v); chk("R6 no alarm before match", v & 32'h1, 0);
    wait_neg(1);
    rd(0, A_STAT, v); chk("R6 alarm on match tick", v & 32'h1, 1);
    chk("R8 alarm_irq gated off", {31'd0, al_a}, 0);
    wr_reg(0, A_STAT, 32'h4);
    rd(0, A_STAT, v); chk("R6 alarm stays set", v & 32'h5, 32'h5);
    chk("R8 alarm_irq on", {31'd0, al_a}, 1);
    wr_reg(0, A_STAT, 32'h5);
    rd(0, A_STAT, v); chk("R7 alarm cleared", v & 32'h5, 32'h4);
    chk("R8 alarm_irq off", {31'd0, al_a}, 0);
  endtask

  task automatic test_trim;
    logic [31:0] v;
    wr_reg(0, A_TRIM, 32'h0);
    wr_reg(0, A_CNT, 32'h0);
    wr_reg(0, A_TRIM, 32'h0003_0001);
    wait_neg(2046);
    rd(0, A_CNT, v); chk("R4 1023 ticks", v, 1023);
    wait_neg(4);
    rd(0, A_CNT, v); chk("R4 lengthened interval", v, 1023);
    wait_neg(1);
    rd(0, A_CNT, v); chk("R4 positive trim tick", v, 1024);
    wait_neg(2);
    rd(0, A_CNT, v); chk("R4 back to base length", v, 1025);
    wr_reg(0, A_TRIM, 32'h0);
    wr_reg(0, A_CNT, 32'h0);
    wr_reg(0, A_TRIM, 32'hFFFE_0003);
    wait_neg(4093);
    rd(0, A_CNT, v); chk("R4 negative trim before", v, 1023);
    wait_neg(1);
    rd(0, A_CNT, v); chk("R4 negative trim tick", v, 1024);
  endtask

  task automatic test_layout;
    logic [31:0] v;
    wr_reg(1, 5'h00, 32'h0000_1234);
    wr_reg(1, 5'h04, 32'h0000_0055);
    wr_reg(1, 5'h10, 32'h0000_0004);
    rd(1, 5'h00, v); chk("R9 alt alarm", v, 32'h1234);
    rd(1, 5'h04, v); chk("R9 alt count", v, 32'h55);
    rd(1, 5'h10, v); chk("R9 alt status", v, 32'h4);
    rd(1, 5'h08, v); chk("R9 alt trim", v, 0);
    rd(1, 5'h0C, v); chk("R9 alt unmapped", v, 0);
    rd(0, 5'h14, v); chk("R9 unmapped", v, 0);
    rd(0, A_ALM, v); chk("R9 primary alarm", v, 7);
  endtask

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    test_reset;
    test_idle;
    test_prescale;
    test_status;
    test_alarm;
    test_trim;
    test_layout;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule